// File: doc/BRIEF.md
# SDRAM Open-Row Access Sequencer

This block turns single-beat host reads and writes into SDRAM command sequences. A host presents a request with an address, a direction, byte enables and a target flag, using a valid/ready handshake. The sequencer keeps one valid bit and one open-row register for each bank. It compares the requested row against that record and picks one of three paths. If the row is already open, it issues the column command at once. If the bank is closed, it issues an activate and then the column command. If a different row is open, it precharges that bank, activates the new row and then issues the column command.

A mode input chooses between keeping rows open and closing them automatically. In the auto-close mode every column command carries the auto-precharge flag and no row is recorded as open. Refresh and bus-release requests start with a precharge of all banks and leave every bank closed. Read byte masks are placed for a mask-to-data delay of two cycles. At CAS latency 1 this requires one idle cycle ahead of the READ command. Initialization, mode-register setup and the data pins are handled outside this block.

Top module: `sdram_row_seq`

## Requirements
- R1: In open-row mode, a request whose bank holds the same open row gets its column command in the cycle after acceptance, with no ACTIVE or PRECHARGE.
- R2: A request whose bank holds a different open row gets PRECHARGE of that bank (A10 low) in the cycle after acceptance, ACTIVE with the new row T_RP cycles later, and the column command T_RCD cycles after the ACTIVE (plus the R4 cycle for a read at CAS latency 1).
- R3: A request to a closed bank gets ACTIVE (bank on BA, row on A) in the cycle after acceptance, and the column command T_RCD cycles later.
- R4: At CAS latency 1 a read has exactly one NOP cycle directly before READ. At latency 2 or 3 no such cycle is added.
- R5: For a read, DQM equals the inverted byte enables in the cycle READ+CL-2. DQM is all ones in every other cycle unless R6 applies. rd_valid pulses for one cycle, CL cycles after READ.
- R6: For a write, DQM equals the inverted byte enables in the WRITE cycle. A disabled lane gives a DQM bit of 1.
- R7: A request with req_sdram low is accepted in one cycle, issues no command and leaves the open-row record unchanged, so the next request to a previously open row is still a hit.
- R8: refresh_req takes priority over a waiting host request. It produces PRECHARGE with A10 high, then AUTO REFRESH T_RP cycles later, then refresh_ack in the last of T_RFC cycles. Afterwards all banks are closed.
- R9: release_req produces an all-bank PRECHARGE. After T_RP cycles release_gnt is held with CS_n high for as long as the request stays high. Afterwards all banks are closed.
- R10: With keep_open low, each column command has A10 high and is followed by T_RP (plus CL for reads) NOP cycles. No row stays open, so a repeated row is activated again. A bank left open earlier is precharged first.
- R11: Command codes on {CS_n,RAS_n,CAS_n,WE_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, deselect 1111. req_addr is {bank[23:22], row[21:9], column[8:0]}. The column is placed on A[8:0], and A10 is the precharge/auto-precharge flag.
- R12: req_ready is high only when the block is idle and neither refresh_req nor release_req is high. While idle the outputs show NOP with address and bank at zero and DQM all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keep_open | input | 1 | 1 keeps rows open, 0 uses auto-precharge |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_sdram | input | 1 | Request targets the SDRAM |
| req_addr | input | 24 | {bank, row, column} |
| req_be | input | 2 | Byte-lane enables |
| rd_valid | output | 1 | Read data capture cycle |
| refresh_req | input | 1 | Refresh request (level) |
| refresh_ack | output | 1 | Last cycle of the refresh sequence |
| release_req | input | 1 | Bus release request (level) |
| release_gnt | output | 1 | Bus released |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row/column address |
| sd_dqm | output | 2 | Byte masks |

## Verification
The bench runs three copies at CAS latencies 1, 2 and 3 from one stimulus stream and compares each of them every cycle against a queue of expected outputs. The targets are the cycle in which the read mask appears and the inserted NOP at latency 1. A design that got these wrong would mask the first data beat, or would gain or lose a cycle before READ. Further targets are hits after a non-SDRAM access, misses against a different open row, and a host request waiting behind a refresh. A design that got these wrong would lose its row record and issue a needless ACTIVE, would issue a column command without precharging, or would let the host slip in ahead of the refresh. Auto-precharge and release traffic check that A10 is set and that no row survives. Otherwise the next access would skip the ACTIVE that the closed bank needs.

// File: rtl/sdram_row_seq.sv
module sdram_row_seq #(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int LANES   = 2,
  parameter int CAS_LAT = 2,
  parameter int T_RP    = 2,
  parameter int T_RCD   = 2,
  parameter int T_RFC   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          keep_open,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic                          req_write,
  input  logic                          req_sdram,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr,
  input  logic [LANES-1:0]              req_be,
  output logic                          rd_valid,
  input  logic                          refresh_req,
  output logic                          refresh_ack,
  input  logic                          release_req,
  output logic                          release_gnt,
  output logic                          sd_cs_n,
  output logic                          sd_ras_n,
  output logic                          sd_cas_n,
  output logic                          sd_we_n,
  output logic [BANK_W-1:0]             sd_ba,
  output logic [ROW_W-1:0]              sd_addr,
  output logic [LANES-1:0]              sd_dqm
);
  localparam int NB     = 1 << BANK_W;
  localparam int TL_MAX = CAS_LAT + T_RP;
  localparam int M1     = (T_RP > T_RCD) ? T_RP : T_RCD;
  localparam int M2     = (M1 > T_RFC) ? M1 : T_RFC;
  localparam int TMAX   = (M2 > TL_MAX) ? M2 : TL_MAX;
  localparam int CW     = $clog2(TMAX + 1);
  localparam int AP_BIT = 10;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_DES = 4'b1111;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_ACT, S_NOPR, S_COL, S_TAIL, S_RPRE, S_RCMD, S_REL
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic q_wr, q_ap, q_ref;
  logic [BANK_W-1:0] q_bank;
  logic [ROW_W-1:0]  q_row;
  logic [COL_W-1:0]  q_col;
  logic [LANES-1:0]  q_be;
  logic [NB-1:0]     open_v;
  logic [NB-1:0][ROW_W-1:0] open_row;

  logic [COL_W-1:0]  r_col;
  logic [ROW_W-1:0]  r_row;
  logic [BANK_W-1:0] r_bank;
  logic hit, first;
  logic [CW-1:0] tl, tpos;
  logic [3:0] cmd;

  assign r_col  = req_addr[COL_W-1:0];
  assign r_row  = req_addr[COL_W +: ROW_W];
  assign r_bank = req_addr[COL_W+ROW_W +: BANK_W];
  assign hit    = keep_open && open_v[r_bank] && (open_row[r_bank] == r_row);
  assign tl     = (q_wr ? CW'(0) : CW'(CAS_LAT)) + (q_ap ? CW'(T_RP) : CW'(0));
  assign tpos   = tl - cnt;
  assign first  = (st == S_PRE || st == S_RPRE) ? (cnt == CW'(T_RP - 1)) :
                  (st == S_ACT)  ? (cnt == CW'(T_RCD - 1)) :
                  (st == S_RCMD) ? (cnt == CW'(T_RFC - 1)) : 1'b0;

  assign req_ready = (st == S_IDLE) && !refresh_req && !release_req;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0;
      q_wr <= 1'b0; q_ap <= 1'b0; q_ref <= 1'b0;
      q_bank <= '0; q_row <= '0; q_col <= '0; q_be <= '0;
      open_v <= '0; open_row <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (refresh_req || release_req) begin
            st <= S_RPRE; cnt <= CW'(T_RP - 1);
            q_ref <= refresh_req; open_v <= '0;
          end else if (req_valid && req_sdram) begin
            q_wr <= req_write; q_ap <= !keep_open; q_bank <= r_bank;
            q_row <= r_row; q_col <= r_col; q_be <= req_be;
            if (hit) st <= (!req_write && CAS_LAT == 1) ? S_NOPR : S_COL;
            else if (open_v[r_bank]) begin st <= S_PRE; cnt <= CW'(T_RP - 1); end
            else begin st <= S_ACT; cnt <= CW'(T_RCD - 1); end
          end
        S_PRE: begin
          if (first) open_v[q_bank] <= 1'b0;
          if (cnt == '0) begin st <= S_ACT; cnt <= CW'(T_RCD - 1); end
          else cnt <= cnt - 1'b1;
        end
        S_ACT: begin
          if (first && !q_ap) begin
            open_v[q_bank] <= 1'b1; open_row[q_bank] <= q_row;
          end
          if (cnt == '0) st <= (!q_wr && CAS_LAT == 1) ? S_NOPR : S_COL;
          else cnt <= cnt - 1'b1;
        end
        S_NOPR: st <= S_COL;
        S_COL:
          if (tl == '0) st <= S_IDLE;
          else begin st <= S_TAIL; cnt <= tl - 1'b1; end
        S_TAIL:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        S_RPRE:
          if (cnt == '0) begin
            if (q_ref) begin st <= S_RCMD; cnt <= CW'(T_RFC - 1); end
            else st <= S_REL;
          end else cnt <= cnt - 1'b1;
        S_RCMD:
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        S_REL:
          if (!release_req) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd = C_NOP; sd_ba = '0; sd_addr = '0; sd_dqm = '1;
    rd_valid = 1'b0; refresh_ack = 1'b0; release_gnt = 1'b0;
    case (st)
      S_PRE:  if (first) begin cmd = C_PRE; sd_ba = q_bank; end
      S_ACT:  if (first) begin cmd = C_ACT; sd_ba = q_bank; sd_addr = q_row; end
      S_NOPR: sd_dqm = ~q_be;
      S_COL: begin
        cmd = q_wr ? C_WR : C_RD;
        sd_ba = q_bank;
        sd_addr = ROW_W'(q_col);
        sd_addr[AP_BIT] = q_ap;
        if (q_wr || CAS_LAT == 2) sd_dqm = ~q_be;
      end
      S_TAIL: begin
        if (!q_wr && CAS_LAT == 3 && tpos == CW'(1)) sd_dqm = ~q_be;
        rd_valid = !q_wr && (tpos == CW'(CAS_LAT));
      end
      S_RPRE: if (first) begin cmd = C_PRE; sd_addr[AP_BIT] = 1'b1; end
      S_RCMD: begin
        if (first) cmd = C_REF;
        refresh_ack = (cnt == '0);
      end
      S_REL: begin cmd = C_DES; release_gnt = 1'b1; end
      default: ;
    endcase
  end

  p_col_row_open_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && sd_ras_n && !sd_cas_n && !sd_addr[AP_BIT])
      |-> (open_v[sd_ba] && open_row[sd_ba] == q_row));

  p_ap_untracked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sd_cs_n && sd_ras_n && !sd_cas_n && sd_addr[AP_BIT]) |-> !open_v[sd_ba]);

  p_refresh_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_REF) |-> (open_v == '0));

  p_gnt_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    release_gnt |-> (sd_cs_n && !req_ready));

  p_rdvalid_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_RD, CAS_LAT));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && sd_dqm == '1));
endmodule

// File: tb/sim_sdram_row_seq.sv
module sim_ref #(
  parameter int CL = 2, parameter int T_RP = 2, parameter int T_RCD = 2,
  parameter int T_RFC = 4
) (
  input logic clk, input logic rst_n, input logic keep_open,
  input logic req_valid, input logic req_write, input logic req_sdram,
  input logic [23:0] req_addr, input logic [1:0] req_be,
  input logic refresh_req, input logic release_req,
  input logic rdy, input logic rv, input logic ack, input logic gnt,
  input logic [3:0] gcmd, input logic [1:0] gba, input logic [12:0] gaddr,
  input logic [1:0] gdqm
);
  typedef struct packed {
    logic [3:0] cmd; logic [1:0] ba; logic [12:0] addr; logic [1:0] dqm;
    logic rv; logic ack; logic gnt; logic [7:0] tag;
  } exp_t;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_DES = 4'b1111;

  integer n_chk = 0, n_fail = 0;
  exp_t q[$];
  bit ov[4];
  logic [12:0] orow[4];
  bit in_rel = 0;

  function automatic string tn(input logic [7:0] t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11"; default: return "R12";
    endcase
  endfunction

  function automatic exp_t mk(input logic [3:0] c, input logic [1:0] b,
      input logic [12:0] a, input logic [1:0] d, input logic v,
      input logic k, input logic g, input int t);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.dqm = d; e.rv = v; e.ack = k;
    e.gnt = g; e.tag = 8'(t);
    return e;
  endfunction

  task automatic nops(input int n, input int t);
    for (int i = 0; i < n; i++) q.push_back(mk(C_NOP, 0, 0, 2'b11, 0, 0, 0, t));
  endtask

  task automatic sched_host();
    logic [1:0] b; logic [12:0] r, ca; logic [8:0] c;
    bit ap, rd, hit, was;
    int tl;
    b = req_addr[23:22]; r = req_addr[21:9]; c = req_addr[8:0];
    ap = !keep_open; rd = !req_write;
    hit = !ap && ov[b] && orow[b] == r;
    if (!hit) begin
      was = ov[b];
      if (was) begin q.push_back(mk(C_PRE, b, 0, 2'b11, 0, 0, 0, 2)); nops(T_RP - 1, 2); end
      q.push_back(mk(C_ACT, b, r, 2'b11, 0, 0, 0, was ? 2 : 3));
      nops(T_RCD - 1, 3);
      ov[b] = !ap; orow[b] = r;
    end
    if (rd && CL == 1) q.push_back(mk(C_NOP, 0, 0, ~req_be, 0, 0, 0, 4));
    ca = {4'd0, c}; ca[10] = ap;
    q.push_back(mk(rd ? C_RD : C_WR, b, ca, (!rd || CL == 2) ? ~req_be : 2'b11, 0, 0, 0,
                   ap ? 10 : (!rd ? 6 : (CL == 1 ? 4 : (hit ? 1 : 5)))));
    tl = (rd ? CL : 0) + (ap ? T_RP : 0);
    for (int i = 1; i <= tl; i++)
      q.push_back(mk(C_NOP, 0, 0, (rd && CL == 3 && i == 1) ? ~req_be : 2'b11,
                     rd && i == CL, 0, 0, ap ? 10 : 5));
  endtask

  task automatic sched_all_pre(input int t);
    for (int i = 0; i < 4; i++) ov[i] = 0;
    q.push_back(mk(C_PRE, 0, 13'h400, 2'b11, 0, 0, 0, t));
    nops(T_RP - 1, t);
  endtask

  always @(negedge clk) if (rst_n) begin
    exp_t e; bit idle, from_rel, bad, erdy;
    idle = 0; from_rel = 0; bad = 0;
    if (q.size() > 0) e = q.pop_front();
    else if (in_rel) begin e = mk(C_DES, 0, 0, 2'b11, 0, 0, 1, 9); from_rel = 1; end
    else begin e = mk(C_NOP, 0, 0, 2'b11, 0, 0, 0, 12); idle = 1; end
    erdy = idle && !refresh_req && !release_req;
    if (gcmd !== e.cmd) begin bad = 1;
      $display("FAIL %s CL%0d cmd (R11 code) got %b exp %b", tn(e.tag), CL, gcmd, e.cmd); end
    if (gba !== e.ba) begin bad = 1;
      $display("FAIL %s CL%0d bank got %0d exp %0d", tn(e.tag), CL, gba, e.ba); end
    if (gaddr !== e.addr) begin bad = 1;
      $display("FAIL %s CL%0d addr got %h exp %h", tn(e.tag), CL, gaddr, e.addr); end
    if (gdqm !== e.dqm) begin bad = 1;
      $display("FAIL %s CL%0d dqm got %b exp %b", tn(e.tag), CL, gdqm, e.dqm); end
    if (rv !== e.rv) begin bad = 1;
      $display("FAIL R5 CL%0d rd_valid got %b exp %b", CL, rv, e.rv); end
    if (ack !== e.ack) begin bad = 1;
      $display("FAIL R8 CL%0d refresh_ack got %b exp %b", CL, ack, e.ack); end
    if (gnt !== e.gnt) begin bad = 1;
      $display("FAIL R9 CL%0d release_gnt got %b exp %b", CL, gnt, e.gnt); end
    if (rdy !== erdy) begin bad = 1;
      $display("FAIL R12 CL%0d req_ready got %b exp %b", CL, rdy, erdy); end
    n_chk++;
    if (bad) n_fail++;
    if (from_rel && !release_req) in_rel = 0;
    if (idle) begin
      if (refresh_req) begin
        sched_all_pre(8);
        if (T_RFC == 1) q.push_back(mk(C_REF, 0, 0, 2'b11, 0, 1, 0, 8));
        else begin
          q.push_back(mk(C_REF, 0, 0, 2'b11, 0, 0, 0, 8));
          nops(T_RFC - 2, 8);
          q.push_back(mk(C_NOP, 0, 0, 2'b11, 0, 1, 0, 8));
        end
      end else if (release_req) begin
        sched_all_pre(9); in_rel = 1;
      end else if (req_valid && req_sdram) sched_host();
    end
  end
endmodule

module sim_sdram_row_seq;
  localparam int CLK_P = 10;
  localparam int TRP = 2, TRCD = 3, TRFC = 4;

  logic clk = 0, rst_n = 0;
  logic keep_open = 1, req_valid = 0, req_write = 0, req_sdram = 1;
  logic [23:0] req_addr = '0;
  logic [1:0] req_be = 2'b11;
  logic refresh_req = 0, release_req = 0;
  logic [2:0] rdy;
  integer t_chk = 0, t_fail = 0, cyc = 0;

  always #(CLK_P / 2) clk = ~clk;

  for (genvar i = 0; i < 3; i++) begin : g_cl
    localparam int CL = (i == 0) ? 2 : ((i == 1) ? 1 : 3);
    logic rdy_w, rv_w, ack_w, gnt_w, cs, ras, cas, we;
    logic [1:0] ba_w, dq_w;
    logic [12:0] ad_w;
    logic [3:0] cmd_w;
    assign cmd_w = {cs, ras, cas, we};
    assign rdy[i] = rdy_w;
    sdram_row_seq #(.CAS_LAT(CL), .T_RP(TRP), .T_RCD(TRCD), .T_RFC(TRFC)) u0 (
      .clk(clk), .rst_n(rst_n), .keep_open(keep_open), .req_valid(req_valid),
      .req_ready(rdy_w), .req_write(req_write), .req_sdram(req_sdram),
      .req_addr(req_addr), .req_be(req_be), .rd_valid(rv_w),
      .refresh_req(refresh_req), .refresh_ack(ack_w), .release_req(release_req),
      .release_gnt(gnt_w), .sd_cs_n(cs), .sd_ras_n(ras), .sd_cas_n(cas),
      .sd_we_n(we), .sd_ba(ba_w), .sd_addr(ad_w), .sd_dqm(dq_w));
    sim_ref #(.CL(CL), .T_RP(TRP), .T_RCD(TRCD), .T_RFC(TRFC)) m0 (
      .clk(clk), .rst_n(rst_n), .keep_open(keep_open), .req_valid(req_valid),
      .req_write(req_write), .req_sdram(req_sdram), .req_addr(req_addr),
      .req_be(req_be), .refresh_req(refresh_req), .release_req(release_req),
      .rdy(rdy_w), .rv(rv_w), .ack(ack_w), .gnt(gnt_w), .gcmd(cmd_w),
      .gba(ba_w), .gaddr(ad_w), .gdqm(dq_w));
  end

  task automatic report();
    integer tot, fl;
    tot = t_chk + g_cl[0].m0.n_chk + g_cl[1].m0.n_chk + g_cl[2].m0.n_chk;
    fl = t_fail + g_cl[0].m0.n_fail + g_cl[1].m0.n_fail + g_cl[2].m0.n_fail;
    $display("[TB] %0d tests run, %0d failed", tot, fl);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    t_chk++;
    if (!ok) begin t_fail++; $display("FAIL %s got %0h exp %0h", tag, got, exp); end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (rdy !== 3'b111);
  endtask

  task automatic host(input bit wr, input bit sd, input int b, input int r,
                      input int c, input logic [1:0] be);
    wait_idle();
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_sdram = sd; req_be = be;
    req_addr = {2'(b), 13'(r), 9'(c)};
    @(posedge clk); #1;
    req_valid = 0; req_sdram = 1;
  endtask

  task automatic refresh(input bit with_host);
    wait_idle();
    @(posedge clk); #1;
    refresh_req = 1;
    if (with_host) begin
      req_valid = 1; req_write = 0; req_be = 2'b01; req_addr = {2'd3, 13'd77, 9'd5};
    end
    do @(negedge clk); while (g_cl[0].ack_w !== 1'b1);
    @(posedge clk); #1;
    refresh_req = 0;
    if (with_host) begin
      @(negedge clk);
      chk(rdy == 3'b111, "R8 waiting host accepted after refresh", rdy, 7);
      @(posedge clk); #1;
      req_valid = 0;
    end
  endtask

  task automatic release_bus(input int n);
    wait_idle();
    @(posedge clk); #1;
    release_req = 1;
    repeat (n) @(posedge clk);
    #1 release_req = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      t_fail++;
      $display("FAIL R12 watchdog got %0d cycles exp fewer", cyc);
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(rdy == 3'b111, "R12 ready after reset", rdy, 7);
    chk(g_cl[0].cmd_w == 4'b0111, "R11 NOP after reset", g_cl[0].cmd_w, 7);
    chk(g_cl[0].dq_w == 2'b11, "R5 masks after reset", g_cl[0].dq_w, 3);

    host(1, 1, 0, 5, 3, 2'b11);
    host(0, 1, 0, 5, 7, 2'b01);
    host(1, 1, 0, 5, 8, 2'b10);
    host(0, 1, 0, 9, 1, 2'b10);
    host(0, 1, 1, 2, 4, 2'b00);
    host(1, 1, 0, 1, 0, 2'b11);
    host(1, 0, 0, 1, 2, 2'b11);
    @(negedge clk);
    chk(rdy == 3'b111, "R7 non-SDRAM request done in one cycle", rdy, 7);
    chk(g_cl[0].cmd_w == 4'b0111, "R7 no command for non-SDRAM", g_cl[0].cmd_w, 7);
    host(1, 1, 0, 1, 6, 2'b01);
    @(negedge clk);
    chk(g_cl[0].cmd_w == 4'b0100, "R7 open row kept, hit gives WRITE", g_cl[0].cmd_w, 4);

    refresh(0);
    host(0, 1, 0, 1, 9, 2'b11);
    refresh(1);
    host(1, 1, 1, 2, 4, 2'b11);
    release_bus(5);
    host(0, 1, 1, 2, 4, 2'b10);
    @(negedge clk);
    chk(g_cl[0].cmd_w == 4'b0011, "R9 banks closed after release", g_cl[0].cmd_w, 3);

    host(1, 1, 2, 40, 1, 2'b11);
    keep_open = 0;
    host(0, 1, 2, 40, 2, 2'b01);
    host(0, 1, 2, 40, 3, 2'b10);
    @(negedge clk);
    chk(g_cl[0].cmd_w == 4'b0011, "R10 same row activated again", g_cl[0].cmd_w, 3);
    host(1, 1, 3, 8191, 511, 2'b10);
    keep_open = 1;

    for (int i = 0; i < 24; i++)
      host(i % 3 == 0, 1, i % 4, (i * 7) % 3, i * 13, 2'(i));
    release_bus(1);
    host(0, 1, 3, 100, 0, 2'b11);
    wait_idle();
    report();
  end
endmodule